// File: doc/BRIEF.md
# Converter Serial Result Streamer with Chain Tag

This block is the digital serial output stage of a sampling converter in self-clocked mode. A start strobe begins conversion n: the convert input and the select input are both low while the external-clock mode input is low. The block then drops its idle flag for a fixed number of system-clock cycles. During that window it produces its own burst of serial clock pulses. On them it shifts out the result of the previous conversion, most significant bit first.

When the conversion window ends, the idle flag rises. On that same edge the new conversion word from the parallel stub input is captured, ready for the next burst. After the last bit, the serial line carries the chain-tag level that was captured during the first pulse. This lets several devices be cascaded by feeding one device's serial output into the next device's tag input.

All timing is counted in system-clock cycles and set by parameters: the delay to the first pulse, the half-period of the serial clock and the conversion length.

Top module: `conv_serial_tx`

## Requirements
- R1: While reset is asserted and right after its release, idle_o is 1, sclk_o is 0 and sout_o is 0.
- R2: A conversion starts only when conv_ni = 0, sel_ni = 0 and mode_ext_i = 0 at a clock edge while idle_o is 1, and idle_o is 0 from that edge on. Any other combination of the three inputs leaves idle_o at 1 and sclk_o at 0, and the word on word_i is not captured.
- R3: idle_o stays 0 for exactly CONV_CYC cycles after the start edge and then returns to 1.
- R4: The first rising edge of sclk_o comes DLY_CYC cycles after the start edge.
- R5: Each conversion produces exactly WIDTH pulses on sclk_o. Each pulse is high for HALF_CYC cycles and low for HALF_CYC cycles. sclk_o is 0 whenever idle_o is 1, and it stays 0 after the last pulse until the next start.
- R6: sout_o changes only while sclk_o is low and not in the first low cycle, so each bit holds across both the rising and the falling edge of its pulse.
- R7: The bits sent during conversion n are the word_i value captured on the edge where idle_o rose at the end of conversion n-1, most significant bit on the first pulse. The first conversion after reset sends all zeros.
- R8: After the last bit, sout_o holds the chain_i level captured during the first pulse of the burst. Later changes of chain_i have no effect on it.
- R9: A start strobe that arrives while idle_o is 0 is ignored. It changes neither the conversion length, the pulse count nor the data sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_ni | input | 1 | Convert request, active low |
| sel_ni | input | 1 | Device select, active low |
| mode_ext_i | input | 1 | 1 selects external serial clocking (no conversions start), 0 selects self-clocked mode |
| chain_i | input | 1 | Chain tag input, echoed after the last data bit |
| word_i | input | WIDTH | Conversion result from the parallel stub register |
| idle_o | output | 1 | 1 when no conversion is running; its rising edge marks the end of the burst |
| sclk_o | output | 1 | Self-generated serial clock |
| sout_o | output | 1 | Serial data, most significant bit first, then the chain tag |

## Verification
The hardest situations to reach from the ports are a second start strobe that arrives in the middle of a running conversion, and a chain_i level that changes after the first pulse has already captured it. The bench pulses the convert and select inputs low at chosen cycles inside the window where idle_o is low. It also inverts chain_i a few cycles after the first rising edge of sclk_o. It then confirms three things: the window length, the pulse count and the trailing tag level are unchanged, and the following conversion still returns the word captured before the stray strobe.

// File: rtl/conv_serial_pkg.sv
package conv_serial_pkg;
  typedef enum logic [1:0] {
    CK_IDLE  = 2'd0,
    CK_DELAY = 2'd1,
    CK_RUN   = 2'd2
  } ck_state_e;
endpackage

// File: rtl/conv_ctrl.sv
module conv_ctrl #(
  parameter int CONV_CYC = 120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_req_i,
  output logic idle_o,
  output logic start_o,
  output logic done_o
);
  localparam int CW = $clog2(CONV_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(CONV_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= 1'b1;
      cnt_q  <= '0;
    end else if (idle_q) begin
      if (start_req_i) begin
        idle_q <= 1'b0;
        cnt_q  <= '0;
      end
    end else if (cnt_q == CNT_LAST) begin
      idle_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // requests while converting are dropped here
  assign start_o = idle_q & start_req_i;
  assign done_o  = ~idle_q & (cnt_q == CNT_LAST);
  assign idle_o  = idle_q;
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import conv_serial_pkg::*;
#(
  parameter int DLY_CYC  = 7,
  parameter int HALF_CYC = 3,
  parameter int NPULSE   = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic sclk_o,
  output logic shift_o,
  output logic tag_smp_o
);
  localparam int DW = $clog2(DLY_CYC + 1);
  localparam int PW = $clog2(2 * HALF_CYC);
  localparam int NW = (NPULSE > 1) ? $clog2(NPULSE) : 1;
  localparam logic [DW-1:0] DLY_LAST  = DW'(DLY_CYC - 1);
  localparam logic [PW-1:0] PH_LAST   = PW'(2 * HALF_CYC - 1);
  localparam logic [PW-1:0] PH_HI_END = PW'(HALF_CYC - 1);
  localparam logic [PW-1:0] PH_SHIFT  = PW'(HALF_CYC);
  localparam logic [NW-1:0] PN_LAST   = NW'(NPULSE - 1);

  ck_state_e     st_q;
  logic [DW-1:0] dly_q;
  logic [PW-1:0] ph_q;
  logic [NW-1:0] pn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CK_IDLE;
      dly_q  <= '0;
      ph_q   <= '0;
      pn_q   <= '0;
      sclk_o <= 1'b0;
    end else begin
      unique case (st_q)
        CK_IDLE: begin
          if (start_i) begin
            st_q  <= CK_DELAY;
            dly_q <= '0;
          end
        end
        CK_DELAY: begin
          if (dly_q == DLY_LAST) begin
            st_q   <= CK_RUN;
            ph_q   <= '0;
            pn_q   <= '0;
            sclk_o <= 1'b1;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        CK_RUN: begin
          if (ph_q == PH_LAST) begin
            ph_q <= '0;
            if (pn_q == PN_LAST) begin
              st_q   <= CK_IDLE;
              sclk_o <= 1'b0;
            end else begin
              pn_q   <= pn_q + 1'b1;
              sclk_o <= 1'b1;
            end
          end else begin
            ph_q   <= ph_q + 1'b1;
            sclk_o <= (ph_q < PH_HI_END);
          end
        end
        default: st_q <= CK_IDLE;
      endcase
    end
  end

  // shift one cycle into the low phase so data holds across the falling edge
  assign shift_o   = (st_q == CK_RUN) && (ph_q == PH_SHIFT);
  assign tag_smp_o = (st_q == CK_RUN) && (ph_q == '0) && (pn_q == '0);
endmodule

// File: rtl/out_shift.sv
module out_shift #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             tag_smp_i,
  input  logic             done_i,
  input  logic             chain_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             sout_o
);
  logic [WIDTH-1:0] res_q;
  logic [WIDTH-1:0] sh_q;
  logic             tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      sh_q  <= '0;
      tag_q <= 1'b0;
    end else begin
      if (done_i)    res_q <= word_i;
      if (tag_smp_i) tag_q <= chain_i;
      if (load_i)       sh_q <= res_q;
      else if (shift_i) sh_q <= {sh_q[WIDTH-2:0], tag_q};
    end
  end

  assign sout_o = sh_q[WIDTH-1];
endmodule

// File: rtl/conv_serial_tx.sv
module conv_serial_tx #(
  parameter int WIDTH    = 16,
  parameter int DLY_CYC  = 7,
  parameter int HALF_CYC = 3,
  parameter int CONV_CYC = 120
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_ni,
  input  logic             sel_ni,
  input  logic             mode_ext_i,
  input  logic             chain_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             idle_o,
  output logic             sclk_o,
  output logic             sout_o
);
  logic start_req, start, done, shift, tag_smp;

  assign start_req = ~conv_ni & ~sel_ni & ~mode_ext_i;

  conv_ctrl #(.CONV_CYC(CONV_CYC)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_req_i(start_req),
    .idle_o     (idle_o),
    .start_o    (start),
    .done_o     (done)
  );

  sclk_gen #(.DLY_CYC(DLY_CYC), .HALF_CYC(HALF_CYC), .NPULSE(WIDTH)) u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .sclk_o   (sclk_o),
    .shift_o  (shift),
    .tag_smp_o(tag_smp)
  );

  out_shift #(.WIDTH(WIDTH)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start),
    .shift_i  (shift),
    .tag_smp_i(tag_smp),
    .done_i   (done),
    .chain_i  (chain_i),
    .word_i   (word_i),
    .sout_o   (sout_o)
  );
endmodule

// File: rtl/conv_serial_tx_chk.sv
module conv_serial_tx_chk #(
  parameter int WIDTH    = 16,
  parameter int CONV_CYC = 120
) (
  input logic clk_i,
  input logic rst_ni,
  input logic conv_ni,
  input logic sel_ni,
  input logic mode_ext_i,
  input logic idle_o,
  input logic sclk_o,
  input logic sout_o
);
  localparam int LW = $clog2(CONV_CYC + 2);
  localparam int PW = $clog2(WIDTH + 2);

  logic [LW-1:0] lo_cnt;
  logic [PW-1:0] pc;
  logic          sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      pc     <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk_o;
      lo_cnt <= idle_o ? '0 : lo_cnt + 1'b1;
      if (idle_o)                pc <= '0;
      else if (sclk_o && !sclk_d) pc <= pc + 1'b1;
    end
  end

  assert_start_cond_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(idle_o) |-> $past(!conv_ni && !sel_ni && !mode_ext_i));

  assert_window_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> lo_cnt == LW'(CONV_CYC));

  assert_sclk_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !idle_o);

  assert_pulse_total_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> pc == PW'(WIDTH));

  assert_pulse_max_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc <= PW'(WIDTH));

  assert_data_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o || $past(sclk_o)) |-> $stable(sout_o));
endmodule

bind conv_serial_tx conv_serial_tx_chk #(.WIDTH(WIDTH), .CONV_CYC(CONV_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .conv_ni   (conv_ni),
  .sel_ni    (sel_ni),
  .mode_ext_i(mode_ext_i),
  .idle_o    (idle_o),
  .sclk_o    (sclk_o),
  .sout_o    (sout_o)
);

// File: tb/conv_serial_tx_tb.sv
module conv_serial_tx_tb;
  localparam int W   = 16;
  localparam int DLY = 7;
  localparam int H   = 3;
  localparam int CNV = 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_n = 1'b1, sel_n = 1'b1, mode_ext = 1'b0, chain = 1'b0;
  logic [W-1:0] word = '0;
  logic idle, sclk, sout;

  int total = 0;
  int bad = 0;
  logic [W-1:0] prev_word = '0;

  always #4 clk = ~clk;

  conv_serial_tx #(.WIDTH(W), .DLY_CYC(DLY), .HALF_CYC(H), .CONV_CYC(CNV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .conv_ni(conv_n), .sel_ni(sel_n),
    .mode_ext_i(mode_ext), .chain_i(chain), .word_i(word),
    .idle_o(idle), .sclk_o(sclk), .sout_o(sout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(idle === 1'b1 && sclk === 1'b0 && sout === 1'b0, "R1 in reset",
        {idle, sclk, sout}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle === 1'b1 && sclk === 1'b0 && sout === 1'b0, "R1 after release",
        {idle, sclk, sout}, 3'b100);
  endtask

  // drive a strobe pattern that must not start a conversion (R2)
  task automatic t_nostart(input logic m, input logic c, input logic s);
    int bad_cyc = 0;
    logic s0;
    @(negedge clk);
    s0 = sout;
    word = 16'hDEAD;
    mode_ext = m; conv_n = c; sel_n = s;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (idle !== 1'b1 || sclk !== 1'b0 || sout !== s0) bad_cyc++;
    end
    mode_ext = 1'b0; conv_n = 1'b1; sel_n = 1'b1;
    chk(bad_cyc == 0, "R2 no start", bad_cyc, 0);
  endtask

  // one conversion; poke >= 0 fires a stray strobe at that sample index (R9)
  task automatic t_conv(input logic [W-1:0] nxt, input logic tg, input int poke);
    int low_cnt = 0, pulses = 0, first = -1, hi = 0, lo = 0, width_bad = 0, tail_bad = 0;
    logic [W-1:0] rise_w = '0, fall_w = '0;
    logic pd = 1'b0;
    logic idle_end = 1'b0;
    @(negedge clk);
    word = nxt;
    chain = tg;
    conv_n = 1'b0; sel_n = 1'b0;
    for (int i = 0; i <= CNV + 1; i++) begin
      @(negedge clk);
      if (i == 0) chk(idle === 1'b0, "R2 start", idle, 0);
      if (i == CNV) idle_end = idle;
      if (sclk && !pd) begin
        pulses++;
        if (first < 0) first = i;
        if (pulses > 1 && lo != H) width_bad++;
        rise_w = {rise_w[W-2:0], sout};
        hi = 1;
      end else if (!sclk && pd) begin
        if (hi != H) width_bad++;
        fall_w = {fall_w[W-2:0], sout};
        lo = 1;
      end else if (sclk) hi++;
      else lo++;
      if (!idle) low_cnt++;
      if (i >= DLY + 2 * W * H && i < CNV && (sout !== tg || sclk !== 1'b0)) tail_bad++;
      pd = sclk;
      // drive after sampling
      if (i == poke) begin conv_n = 1'b0; sel_n = 1'b0; end
      else begin conv_n = 1'b1; sel_n = 1'b1; end
      if (i == DLY + H + 1) chain = ~tg;
    end
    chk(low_cnt == CNV && idle_end === 1'b1, "R3 window", low_cnt, CNV);
    chk(first == DLY, "R4 first rise", first, DLY);
    chk(pulses == W && width_bad == 0, "R5 pulses", pulses, W);
    chk(rise_w == prev_word, "R7 data", rise_w, prev_word);
    chk(fall_w == rise_w, "R6 hold across fall", fall_w, rise_w);
    chk(tail_bad == 0, "R8 tag tail", tail_bad, 0);
    if (poke >= 0) chk(low_cnt == CNV && pulses == W, "R9 stray start", low_cnt, CNV);
    prev_word = nxt;
  endtask

  initial begin
    t_reset();
    t_conv(16'hA5C3, 1'b0, -1);
    t_conv(16'h8001, 1'b1, -1);
    t_nostart(1'b1, 1'b0, 1'b0);
    t_nostart(1'b0, 1'b0, 1'b1);
    t_nostart(1'b0, 1'b1, 1'b0);
    t_conv(16'h1234, 1'b0, 30);
    t_conv(16'hFFFF, 1'b1, -1);
    t_conv(16'h0000, 1'b0, 50);
    t_conv(16'h5A0F, 1'b1, 5);
    t_conv(16'h0001, 1'b0, -1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule